// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt entry control for a CPU datapath built around an accumulator. An interrupt is accepted only at an instruction boundary while interrupts are enabled. Once accepted, the block runs four register-transfer steps, one clock each:

1. The current program counter goes into the buffer register.
2. The fixed save address goes into the address register.
3. The program counter is redirected to the fixed service-routine address.
4. The buffer register is written to memory at the address register.

At the end, execution continues at the service routine and the interrupted program counter is held in a known memory word.

The block owns the buffer and address registers. It reads the program counter, which lives outside the block, and requests a load of that register. It drives a single-port synchronous memory write. It also holds the interrupt-enable flag. The flag clears on entry, so nested entry is impossible until software sets it again through a dedicated strobe. A request that cannot be taken yet is remembered until it can be.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `int_en` is 1. `pc_load`, `mem_we` and `irq_ack` are 0. `mar_q` and `mbr_q` are 0.
- R2: A request is accepted at a rising edge in whose cycle `insn_boundary`=1, `int_en`=1 and either `irq_req`=1 or a request is pending. The first step occupies the cycle after that edge, and the four steps take exactly four consecutive cycles.
- R3: A request seen while `insn_boundary`=0 is held pending. It produces no `pc_load` or `mem_we` until a later cycle with `insn_boundary`=1 accepts it.
- R4: At the edge that ends step 1, `mbr_q` takes the `pc_cur` value present during step 1.
- R5: At the edge that ends step 2, `mar_q` takes the parameter `SAVE_ADDR`.
- R6: During step 3, and only then, `pc_load`=1 with `pc_next`=`SVC_ADDR`.
- R7: During step 4, `mem_we`=1, `mem_addr`=`SAVE_ADDR` and `mem_wdata` holds the program counter from before the interrupt. `irq_ack` is high for exactly that one cycle.
- R8: `int_en` clears at the accepting edge. A request made while `int_en`=0 is held pending and is not taken until `ie_set` is pulsed while idle.
- R9: `ie_set` has no effect while a sequence is in progress, so `int_en` stays 0 after the sequence.
- R10: A request that arrives during a sequence is held pending. It is accepted after re-enable at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request, may be a single-cycle pulse |
| insn_boundary | input | 1 | High in cycles where an instruction has completed |
| ie_set | input | 1 | Software re-enable strobe for the interrupt flag |
| pc_cur | input | PC_W | Current program counter value |
| pc_load | output | 1 | Load strobe for the program counter |
| pc_next | output | PC_W | Value to load into the program counter |
| mar_q | output | AW | Memory address register |
| mbr_q | output | PC_W | Memory buffer register |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | PC_W | Memory write data |
| irq_ack | output | 1 | Single-cycle acknowledge, coincident with the save write |
| int_en | output | 1 | Interrupt enable flag |

## Verification
Some properties are checked on every cycle:
- The save write always targets the save word and carries the program counter from three cycles earlier.
- The redirect is always followed immediately by the acknowledged write.
- The acknowledge never lasts more than one cycle and never appears with interrupts enabled.
- A falling enable flag always leads to the redirect two cycles later.

Other behaviour needs the bench's scenarios to show. This covers holding a request across non-boundary cycles, holding it across a masked period, and holding it across a running sequence. It also covers ignoring a re-enable strobe mid-sequence and resuming at the service address with the old value stored.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int PC_W = 16,
  parameter int AW   = 16,
  parameter logic [AW-1:0]   SAVE_ADDR = AW'(16'h0040),
  parameter logic [PC_W-1:0] SVC_ADDR  = PC_W'(16'h0100)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            insn_boundary,
  input  logic            ie_set,
  input  logic [PC_W-1:0] pc_cur,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic [AW-1:0]   mar_q,
  output logic [PC_W-1:0] mbr_q,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [PC_W-1:0] mem_wdata,
  output logic            irq_ack,
  output logic            int_en
);
  typedef enum logic [2:0] {IDLE, ST_MBR, ST_MAR, ST_PC, ST_WR} step_t;
  step_t state;
  logic  pending, take, idle;

  assign idle = (state == IDLE);
  assign take = idle && insn_boundary && int_en && (pending || irq_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      pending <= 1'b0;
      int_en  <= 1'b1;
      mbr_q   <= '0;
      mar_q   <= '0;
    end else begin
      if (take)         pending <= 1'b0;
      else if (irq_req) pending <= 1'b1;

      if (take)                int_en <= 1'b0;
      else if (ie_set && idle) int_en <= 1'b1;

      if (state == ST_MBR) mbr_q <= pc_cur;
      if (state == ST_MAR) mar_q <= SAVE_ADDR;

      unique case (state)
        IDLE:    state <= take ? ST_MBR : IDLE;
        ST_MBR:  state <= ST_MAR;
        ST_MAR:  state <= ST_PC;
        ST_PC:   state <= ST_WR;
        default: state <= IDLE;
      endcase
    end
  end

  assign pc_load   = (state == ST_PC);
  assign pc_next   = SVC_ADDR;
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign irq_ack   = mem_we;

  assert_save_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == SAVE_ADDR && mem_wdata == $past(pc_cur, 3)));

  assert_redirect_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (irq_ack && !pc_load));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  assert_masked_in_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !int_en);

  assert_entry_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> ##2 pc_load);
endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
  localparam int PC_W = 16;
  localparam int AW   = 16;
  localparam logic [AW-1:0]   SAVE = 16'h0040;
  localparam logic [PC_W-1:0] SVC  = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_req = 0, insn_boundary = 0, ie_set = 0;
  logic pc_load, mem_we, irq_ack, int_en;
  logic [PC_W-1:0] pc_next, mbr_q, mem_wdata, pc_reg, pc_wdata;
  logic [AW-1:0] mar_q, mem_addr;
  logic pc_wr = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq #(.PC_W(PC_W), .AW(AW), .SAVE_ADDR(SAVE), .SVC_ADDR(SVC)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .ie_set(ie_set), .pc_cur(pc_reg), .pc_load(pc_load), .pc_next(pc_next),
    .mar_q(mar_q), .mbr_q(mbr_q), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq_ack(irq_ack), .int_en(int_en));

  always @(posedge clk)
    if (!rst_n) pc_reg <= '0;
    else if (pc_load) pc_reg <= pc_next;
    else if (pc_wr) pc_reg <= pc_wdata;

  function automatic logic [AW-1:0] exp_save_addr();
    return SAVE;
  endfunction
  function automatic logic [PC_W-1:0] exp_target();
    return SVC;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  task automatic set_pc(input logic [PC_W-1:0] v);
    pc_wr = 1; pc_wdata = v; nclk(); pc_wr = 0;
  endtask

  // caller has set insn_boundary=1 so the next posedge accepts
  task automatic run_entry(input logic [PC_W-1:0] oldpc);
    nclk(); insn_boundary = 0;                       // step 1
    check(!pc_load && !mem_we, "R2 step1 quiet", {pc_load, mem_we}, 0);
    check(int_en == 0, "R8 enable cleared", int_en, 0);
    nclk();                                          // step 2
    check(mbr_q == oldpc, "R4 mbr", mbr_q, oldpc);
    check(!pc_load, "R2 step2 no load", pc_load, 0);
    nclk();                                          // step 3
    check(mar_q == exp_save_addr(), "R5 mar", mar_q, exp_save_addr());
    check(pc_load && pc_next == exp_target(), "R6 redirect", pc_next, exp_target());
    check(!mem_we, "R6 no write yet", mem_we, 0);
    nclk();                                          // step 4
    check(mem_we && irq_ack, "R7 write+ack", {mem_we, irq_ack}, 3);
    check(mem_addr == exp_save_addr(), "R7 addr", mem_addr, exp_save_addr());
    check(mem_wdata == oldpc, "R7 data", mem_wdata, oldpc);
    check(pc_reg == exp_target(), "R6 pc resumed", pc_reg, exp_target());
    check(!pc_load, "R6 single load", pc_load, 0);
    nclk();
    check(!irq_ack && !mem_we, "R7 ack one cycle", irq_ack, 0);
    check(!int_en, "R8 still masked", int_en, 0);
  endtask

  task automatic reenable();
    ie_set = 1; nclk(); ie_set = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) nclk();
    rst_n = 1; nclk();
    check(int_en == 1, "R1 int_en", int_en, 1);
    check(!pc_load && !mem_we && !irq_ack, "R1 strobes", {pc_load, mem_we, irq_ack}, 0);
    check(mar_q == 0 && mbr_q == 0, "R1 regs", {mar_q, mbr_q}, 0);

    // directed: same-cycle accept
    set_pc(16'h1234);
    irq_req = 1; insn_boundary = 1;
    nclk(); irq_req = 0;
    insn_boundary = 0;
    // accept happened at that edge; entry already in step 1 now
    check(!int_en, "R2 accepted same cycle", int_en, 0);
    nclk(); check(mbr_q == 16'h1234, "R4 mbr direct", mbr_q, 16'h1234);
    nclk(); check(pc_load, "R6 load direct", pc_load, 1);
    nclk(); check(mem_wdata == 16'h1234 && irq_ack, "R7 direct", mem_wdata, 16'h1234);
    nclk(); reenable();

    // R9: ie_set during entry is ignored
    set_pc(16'hBEEF);
    irq_req = 1; nclk(); irq_req = 0;
    insn_boundary = 1;
    nclk(); insn_boundary = 0; ie_set = 1;
    nclk(); nclk(); ie_set = 0; nclk(); nclk();
    check(!int_en, "R9 ie_set ignored in entry", int_en, 0);

    // R8: request while masked is held until re-enable
    irq_req = 1; insn_boundary = 1; nclk(); irq_req = 0;
    repeat (3) nclk();
    check(!pc_load && !mem_we, "R8 masked no entry", {pc_load, mem_we}, 0);
    insn_boundary = 0;
    reenable();
    check(int_en, "R8 re-enabled", int_en, 1);
    set_pc(16'h0777);
    insn_boundary = 1;
    run_entry(16'h0777);

    // R10: request during an entry is kept
    reenable();
    set_pc(16'h2222);
    irq_req = 1; insn_boundary = 1; nclk(); irq_req = 0; insn_boundary = 0;
    nclk(); irq_req = 1; nclk(); irq_req = 0;
    repeat (4) nclk();
    reenable();
    set_pc(16'h3333);
    insn_boundary = 1;
    run_entry(16'h3333);

    // random trials: R3 pending across non-boundary cycles
    for (int t = 0; t < 40; t++) begin
      logic [PC_W-1:0] v;
      int k;
      v = PC_W'($urandom);
      k = $urandom_range(0, 6);
      reenable();
      set_pc(v);
      irq_req = 1; nclk(); irq_req = 0;
      for (int i = 0; i < k; i++) begin
        nclk();
        check(!pc_load && !mem_we && int_en, "R3 held pending", {pc_load, mem_we, int_en}, 1);
      end
      insn_boundary = 1;
      run_entry(v);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule